// File: doc/BRIEF.md
# Prioritized Interrupt Dispatch Controller

This block sits beside a small 8-bit processor core and decides which of five interrupt sources is serviced next. It keeps a request-flag register and a source-enable register, both reachable through a byte-wide register port, and a global interrupt-enable bit (the master enable). Peripherals raise requests with single-cycle pulses. Each time the core reports a finished step, the controller looks at the sources that are both requested and enabled. If the master enable is set, it takes the highest-priority one. It then emits a one-cycle dispatch strobe with a 16-bit vector address, clears that source's request flag, and drops the master enable.

The controller also models the core's halted state. A halt request stops instruction fetch. While halted, the block paces itself in idle steps of a fixed number of clocks and performs the same interrupt check at the end of every idle step. Any requested-and-enabled source ends the halt, even when the master enable is clear. In that case no dispatch follows, and a status pulse marks that the wake happened with interrupts disabled.

Top module: `irq_dispatch`

## Requirements
- R1: After reset the request flags, the source enables and the master enable are all 0. The block is not halted, `fetch_en` is 1, and no dispatch strobe is active.
- R2: A write to address 0xFF0F loads the request flags from data bits 4:0, and a read there returns the flags with bits 7:5 read as 1. A write to 0xFFFF loads the enables from bits 4:0, and a read returns them with bits 7:5 as 0. Any other address reads 0x00.
- R3: A request pulse sets its flag bit. A pulse that arrives in the same cycle as a flag-register write is ORed into the written value.
- R4: Bit 0 is vertical blank, bit 1 LCD status, bit 2 timer, bit 3 serial and bit 4 joypad. Priority runs from bit 0 (highest) to bit 4. The vectors are 0x40, 0x48, 0x50, 0x58 and 0x60 respectively.
- R5: A source is dispatched only at a check point (a `step_done` pulse while running, or the end of an idle step while halted), and only when the master enable is 1 and both the source's flag and its enable are 1.
- R6: A dispatch clears only the chosen source's flag. The enable register and lower-priority flags are unchanged.
- R7: A dispatch clears the master enable, and this takes precedence over a same-cycle `ime_set`. `disp_valid` and `disp_vector` appear in the cycle after the check point.
- R8: After a `halt_req`, `halted` is 1 and `fetch_en` is 0. `idle_step` pulses once every 4 clocks, and `step_done` has no effect while halted.
- R9: At the end of an idle step with any flag AND enable bit set, the halted state is left whatever the master enable is. A dispatch follows only if the master enable is 1.
- R10: A wake from halt while the master enable is 0 produces a one-cycle `wake_no_ime` pulse. The flags are left untouched and no dispatch occurs.
- R11: A request pulse for the source being dispatched in the same cycle leaves that flag set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 16 | Register address |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data (combinational from `reg_addr`) |
| src_pulse | input | 5 | Per-source request pulses |
| ime_set | input | 1 | Set master enable |
| ime_clr | input | 1 | Clear master enable |
| ime | output | 1 | Master enable state |
| step_done | input | 1 | Core finished a step (check point while running) |
| halt_req | input | 1 | Enter halted state |
| halted | output | 1 | Halted state |
| fetch_en | output | 1 | Instruction fetch permitted |
| idle_step | output | 1 | One idle step of 4 clocks completes this cycle |
| disp_valid | output | 1 | Dispatch strobe |
| disp_vector | output | 16 | Vector address of the dispatched source |
| wake_no_ime | output | 1 | Halt left with master enable clear |

## Verification
Two functions can land in the same cycle and target the same flag bit: a peripheral request pulse, and either a software write to the flag register or the clear that a dispatch performs. The bench provokes both collisions. It drives a write of 0x00 to 0xFF0F together with a joypad pulse, and it drives a `step_done` that dispatches joypad together with a new joypad pulse. In both cases the flag register is read back afterwards and must show the bit still set. A scoreboard of expected vectors confirms that exactly one dispatch happened in the second case.

// File: rtl/irq_dispatch_pkg.sv
package irq_dispatch_pkg;
   localparam int unsigned IRQ_NSRC_DEF  = 5;
   localparam int unsigned IRQ_STEP_DEF  = 4;

   function automatic logic [15:0] irq_vec_at(input int unsigned base,
                                              input int unsigned stride,
                                              input int unsigned idx);
      return 16'(base + idx * stride);
   endfunction
endpackage

// File: rtl/irq_regs.sv
module irq_regs #(
   parameter int unsigned NSRC      = 5,
   parameter int unsigned AW        = 16,
   parameter int unsigned DW        = 8,
   parameter logic [15:0] FLAG_ADDR = 16'hFF0F,
   parameter logic [15:0] EN_ADDR   = 16'hFFFF
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            wr,
   input  logic [AW-1:0]   addr,
   input  logic [DW-1:0]   wdata,
   input  logic [NSRC-1:0] src_pulse,
   input  logic [NSRC-1:0] clr_mask,
   output logic [DW-1:0]   rdata,
   output logic [NSRC-1:0] flags,
   output logic [NSRC-1:0] enables
);
   localparam int unsigned PAD = DW - NSRC;

   if (NSRC < 1 || NSRC >= DW) begin : g_bad_width
      $error("irq_regs: NSRC must be between 1 and DW-1");
   end

   logic hit_flag, hit_en;
   logic [NSRC-1:0] flag_base, flag_nxt;
   logic unused_hi;

   assign hit_flag  = (addr == AW'(FLAG_ADDR));
   assign hit_en    = (addr == AW'(EN_ADDR));
   assign unused_hi = ^wdata[DW-1:NSRC];

   // write first, then dispatch clear, then peripheral pulses win
   assign flag_base = (wr && hit_flag) ? wdata[NSRC-1:0] : flags;
   assign flag_nxt  = (flag_base & ~clr_mask) | src_pulse;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         flags   <= '0;
         enables <= '0;
      end else begin
         flags <= flag_nxt;
         if (wr && hit_en) enables <= wdata[NSRC-1:0];
      end
   end

   always_comb begin
      if (hit_flag)    rdata = {{PAD{1'b1}}, flags};
      else if (hit_en) rdata = {{PAD{1'b0}}, enables};
      else             rdata = '0;
   end

   // R11: a pulse is never lost, whatever else happened that cycle
   a_r11_pulse_kept: assert property (@(posedge clk) disable iff (!rst_n)
      (|src_pulse) |=> ((flags & $past(src_pulse)) == $past(src_pulse)));
endmodule

// File: rtl/irq_arbiter.sv
module irq_arbiter #(
   parameter int unsigned NSRC       = 5,
   parameter int unsigned VAW        = 16,
   parameter int unsigned VEC_BASE   = 'h40,
   parameter int unsigned VEC_STRIDE = 8
) (
   input  logic [NSRC-1:0] pend,
   output logic [NSRC-1:0] grant,
   output logic            any,
   output logic [VAW-1:0]  vector
);
   if (VEC_STRIDE == 0) begin : g_bad_stride
      $error("irq_arbiter: VEC_STRIDE must be nonzero");
   end

   logic [NSRC:0] seen;
   logic [VAW-1:0] vec_term [NSRC];

   assign seen[0] = 1'b0;

   for (genvar i = 0; i < NSRC; i++) begin : g_chain
      assign grant[i]    = pend[i] & ~seen[i];
      assign seen[i+1]   = seen[i] | pend[i];
      assign vec_term[i] = grant[i] ? VAW'(irq_dispatch_pkg::irq_vec_at(VEC_BASE, VEC_STRIDE, i))
                                    : '0;
   end

   assign any = seen[NSRC];

   always_comb begin
      vector = '0;
      for (int k = 0; k < NSRC; k++) vector = vector | vec_term[k];
   end
endmodule

// File: rtl/irq_halt_seq.sv
module irq_halt_seq #(
   parameter int unsigned STEP = 4
) (
   input  logic clk,
   input  logic rst_n,
   input  logic halt_req,
   input  logic step_done,
   input  logic pend_any,
   output logic halted,
   output logic idle_step,
   output logic chk,
   output logic wake
);
   localparam int unsigned CW = (STEP > 2) ? $clog2(STEP) : 1;
   localparam logic [CW-1:0] LAST = CW'(STEP - 1);

   if (STEP < 2) begin : g_bad_step
      $error("irq_halt_seq: STEP must be at least 2");
   end

   logic [CW-1:0] cnt;

   assign idle_step = halted && (cnt == LAST);
   assign chk       = halted ? idle_step : step_done;
   assign wake      = idle_step && pend_any;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         halted <= 1'b0;
         cnt    <= '0;
      end else if (!halted) begin
         if (halt_req) begin
            halted <= 1'b1;
            cnt    <= '0;
         end
      end else if (idle_step) begin
         cnt <= '0;
         if (pend_any) halted <= 1'b0;
      end else begin
         cnt <= cnt + 1'b1;
      end
   end

   // R8: idle steps are separated by at least one clock
   a_r8_idle_spacing: assert property (@(posedge clk) disable iff (!rst_n)
      idle_step |=> !idle_step);
   // R9: a pending source at the end of an idle step ends the halt
   a_r9_wake_leaves: assert property (@(posedge clk) disable iff (!rst_n)
      (idle_step && pend_any) |=> !halted);
endmodule

// File: rtl/irq_dispatch.sv
module irq_dispatch
   import irq_dispatch_pkg::*;
#(
   parameter int unsigned NSRC       = IRQ_NSRC_DEF,
   parameter int unsigned AW         = 16,
   parameter int unsigned DW         = 8,
   parameter logic [15:0] FLAG_ADDR  = 16'hFF0F,
   parameter logic [15:0] EN_ADDR    = 16'hFFFF,
   parameter int unsigned VEC_BASE   = 'h40,
   parameter int unsigned VEC_STRIDE = 8,
   parameter int unsigned HALT_STEP  = IRQ_STEP_DEF
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            reg_wr,
   input  logic [AW-1:0]   reg_addr,
   input  logic [DW-1:0]   reg_wdata,
   output logic [DW-1:0]   reg_rdata,
   input  logic [NSRC-1:0] src_pulse,
   input  logic            ime_set,
   input  logic            ime_clr,
   output logic            ime,
   input  logic            step_done,
   input  logic            halt_req,
   output logic            halted,
   output logic            fetch_en,
   output logic            idle_step,
   output logic            disp_valid,
   output logic [AW-1:0]   disp_vector,
   output logic            wake_no_ime
);
   logic [NSRC-1:0] flags, enables, pend, grant, clr_mask;
   logic            any, chk, wake, dispatch;
   logic [AW-1:0]   vec_w;
   logic            ime_q, disp_q, wake_ni_q;
   logic [AW-1:0]   vec_q;

   assign pend     = flags & enables;
   assign dispatch = chk & ime_q & any;
   assign clr_mask = dispatch ? grant : '0;

   irq_regs #(
      .NSRC(NSRC), .AW(AW), .DW(DW), .FLAG_ADDR(FLAG_ADDR), .EN_ADDR(EN_ADDR)
   ) u_regs (
      .clk(clk), .rst_n(rst_n), .wr(reg_wr), .addr(reg_addr), .wdata(reg_wdata),
      .src_pulse(src_pulse), .clr_mask(clr_mask), .rdata(reg_rdata),
      .flags(flags), .enables(enables)
   );

   irq_arbiter #(
      .NSRC(NSRC), .VAW(AW), .VEC_BASE(VEC_BASE), .VEC_STRIDE(VEC_STRIDE)
   ) u_arb (
      .pend(pend), .grant(grant), .any(any), .vector(vec_w)
   );

   irq_halt_seq #(.STEP(HALT_STEP)) u_halt (
      .clk(clk), .rst_n(rst_n), .halt_req(halt_req), .step_done(step_done),
      .pend_any(any), .halted(halted), .idle_step(idle_step), .chk(chk),
      .wake(wake)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         ime_q     <= 1'b0;
         disp_q    <= 1'b0;
         vec_q     <= '0;
         wake_ni_q <= 1'b0;
      end else begin
         if (dispatch)     ime_q <= 1'b0;
         else if (ime_set) ime_q <= 1'b1;
         else if (ime_clr) ime_q <= 1'b0;
         disp_q    <= dispatch;
         if (dispatch) vec_q <= vec_w;
         wake_ni_q <= wake & ~ime_q;
      end
   end

   assign ime         = ime_q;
   assign fetch_en    = ~halted;
   assign disp_valid  = disp_q;
   assign disp_vector = vec_q;
   assign wake_no_ime = wake_ni_q;

   // R7: the master enable is down whenever a dispatch is presented
   a_r7_ime_drop: assert property (@(posedge clk) disable iff (!rst_n)
      disp_valid |-> !ime);
   // R5: a dispatch only follows a cycle with the master enable set
   a_r5_needs_ime: assert property (@(posedge clk) disable iff (!rst_n)
      disp_valid |-> $past(ime));
   // R4: the arbiter never grants more than one source
   a_r4_one_grant: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(grant));
   // R4: a grant always points at a requested-and-enabled source
   a_r4_grant_pending: assert property (@(posedge clk) disable iff (!rst_n)
      (grant & ~pend) == '0);
endmodule

// File: tb/irq_dispatch_bench.sv
module irq_dispatch_bench;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        reg_wr = 1'b0;
   logic [15:0] reg_addr = 16'h0000;
   logic [7:0]  reg_wdata = 8'h00;
   logic [7:0]  reg_rdata;
   logic [4:0]  src_pulse = 5'b0;
   logic        ime_set = 1'b0, ime_clr = 1'b0, ime;
   logic        step_done = 1'b0, halt_req = 1'b0;
   logic        halted, fetch_en, idle_step, disp_valid, wake_no_ime;
   logic [15:0] disp_vector;

   int n_chk = 0, n_fail = 0, wake_cnt = 0;
   logic [15:0] exp_q[$];

   always #2.5 clk = ~clk;

   irq_dispatch u_irq_dispatch (
      .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
      .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .src_pulse(src_pulse),
      .ime_set(ime_set), .ime_clr(ime_clr), .ime(ime), .step_done(step_done),
      .halt_req(halt_req), .halted(halted), .fetch_en(fetch_en),
      .idle_step(idle_step), .disp_valid(disp_valid), .disp_vector(disp_vector),
      .wake_no_ime(wake_no_ime)
   );

   task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual %h expected %h", req, act, exp);
      end
   endtask

   // monitor: pops expected vectors as dispatches appear
   always @(negedge clk) begin
      if (rst_n && disp_valid) begin
         if (exp_q.size() == 0) begin
            check("R5 unexpected dispatch", disp_vector, 16'hxxxx);
         end else begin
            check("R4 dispatch vector", disp_vector, exp_q.pop_front());
         end
      end
      if (rst_n && wake_no_ime) wake_cnt++;
   end

   task automatic wr(input logic [15:0] a, input logic [7:0] d);
      reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
      @(negedge clk);
      reg_wr = 1'b0;
   endtask

   task automatic rd(input logic [15:0] a, output logic [7:0] d);
      reg_addr = a; #1; d = reg_rdata;
   endtask

   task automatic step(input logic [4:0] p, input logic iset);
      step_done = 1'b1; src_pulse = p; ime_set = iset;
      @(negedge clk);
      step_done = 1'b0; src_pulse = '0; ime_set = 1'b0;
   endtask

   task automatic pulse_ime();
      ime_set = 1'b1; @(negedge clk); ime_set = 1'b0;
   endtask

   task automatic pulse_src(input logic [4:0] p);
      src_pulse = p; @(negedge clk); src_pulse = '0;
   endtask

   task automatic wait_wake();
      for (int t = 0; t < 10 && halted; t++) @(negedge clk);
      check("R9 halt left", {15'b0, halted}, 16'h0000);
   endtask

   initial begin
      #(200000 * 5.0);
      n_fail++;
      $display("FAIL watchdog: actual running expected done");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
   end

   initial begin
      logic [7:0] d;
      int steps;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);

      // R1 reset state
      rd(16'hFF0F, d); check("R1 flags", {8'h0, d}, 16'h00E0);
      rd(16'hFFFF, d); check("R1 enables", {8'h0, d}, 16'h0000);
      check("R1 ime/halt/fetch/disp", {12'h0, ime, halted, fetch_en, disp_valid}, 16'h0002);

      // R2 register access
      wr(16'hFFFF, 8'hFF);
      rd(16'hFFFF, d); check("R2 enable readback", {8'h0, d}, 16'h001F);
      wr(16'hFF0F, 8'h0A);
      rd(16'hFF0F, d); check("R2 flag readback", {8'h0, d}, 16'h00EA);
      rd(16'h1234, d); check("R2 other address", {8'h0, d}, 16'h0000);

      // R5 no dispatch without master enable
      step(5'b0, 1'b0);
      @(negedge clk);
      rd(16'hFF0F, d); check("R5 flags kept when ime clear", {8'h0, d}, 16'h00EA);

      // R4 R6 R7 priority with two pending
      pulse_ime();
      exp_q.push_back(16'h0048);
      step(5'b0, 1'b0);
      rd(16'hFF0F, d); check("R6 only chosen flag cleared", {8'h0, d}, 16'h00E8);
      rd(16'hFFFF, d); check("R6 enables unchanged", {8'h0, d}, 16'h001F);
      check("R7 ime dropped", {15'b0, ime}, 16'h0000);
      pulse_ime();
      exp_q.push_back(16'h0058);
      step(5'b0, 1'b0);
      rd(16'hFF0F, d); check("R6 flags after second dispatch", {8'h0, d}, 16'h00E0);

      // R4 full priority walk
      wr(16'hFF0F, 8'h1F);
      for (int i = 0; i < 5; i++) begin
         pulse_ime();
         exp_q.push_back(16'h0040 + 16'(i * 8));
         step(5'b0, 1'b0);
      end
      rd(16'hFF0F, d); check("R4 all serviced", {8'h0, d}, 16'h00E0);

      // R5 enable masking
      wr(16'hFFFF, 8'h04);
      wr(16'hFF0F, 8'h03);
      pulse_ime();
      step(5'b0, 1'b0);
      @(negedge clk);
      check("R5 masked sources ignored, ime kept", {15'b0, ime}, 16'h0001);
      pulse_src(5'b00100);
      exp_q.push_back(16'h0050);
      step(5'b0, 1'b0);
      rd(16'hFF0F, d); check("R5 timer cleared, masked kept", {8'h0, d}, 16'h00E3);

      // R3 write colliding with a pulse
      wr(16'hFFFF, 8'h1F);
      src_pulse = 5'b10000;
      wr(16'hFF0F, 8'h00);
      src_pulse = '0;
      rd(16'hFF0F, d); check("R3 pulse merged with write", {8'h0, d}, 16'h00F0);

      // R11 dispatch colliding with a pulse of the same source
      pulse_ime();
      exp_q.push_back(16'h0060);
      step(5'b10000, 1'b0);
      rd(16'hFF0F, d); check("R11 flag survives dispatch", {8'h0, d}, 16'h00F0);

      // R7 ime_set same cycle as dispatch
      pulse_ime();
      exp_q.push_back(16'h0060);
      step(5'b0, 1'b1);
      check("R7 dispatch beats ime_set", {15'b0, ime}, 16'h0000);

      // R8 halted pacing
      wr(16'hFF0F, 8'h00);
      halt_req = 1'b1; @(negedge clk); halt_req = 1'b0;
      steps = 0;
      for (int c = 0; c < 12; c++) begin
         step_done = 1'b1;
         if (fetch_en !== 1'b0) check("R8 fetch blocked", {15'b0, fetch_en}, 16'h0000);
         if (idle_step) steps++;
         @(negedge clk);
      end
      step_done = 1'b0;
      check("R8 idle steps in 12 clocks", 16'(steps), 16'd3);
      check("R8 still halted", {15'b0, halted}, 16'h0001);

      // R9 R10 wake with master enable clear
      pulse_src(5'b00010);
      wait_wake();
      @(negedge clk);
      check("R10 wake_no_ime pulses", 16'(wake_cnt), 16'd1);
      rd(16'hFF0F, d); check("R10 flags untouched", {8'h0, d}, 16'h00E2);
      check("R9 fetch resumes", {15'b0, fetch_en}, 16'h0001);

      // R9 wake with master enable set dispatches
      wr(16'hFF0F, 8'h00);
      halt_req = 1'b1; @(negedge clk); halt_req = 1'b0;
      pulse_ime();
      exp_q.push_back(16'h0040);
      pulse_src(5'b00001);
      wait_wake();
      repeat (2) @(negedge clk);
      rd(16'hFF0F, d); check("R9 serviced on wake", {8'h0, d}, 16'h00E0);
      check("R10 no extra wake_no_ime", 16'(wake_cnt), 16'd1);

      check("R4 scoreboard drained", 16'(exp_q.size()), 16'd0);
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
   end
endmodule